// File: doc/BRIEF.md
# Stop Mode Controller

This block sits beside a small microcontroller core and manages its stop states. When the core strobes a stop request with a target level (stop1, stop2 or stop3), the controller decides which level is really entered. It then drops the peripheral clock enables, decides whether the supply regulator may go to standby, and keeps the debug clock alive if debug is enabled. A deep level (stop1 or stop2) is quietly replaced by stop3 whenever the debug logic or the low-voltage detector has to keep working through the stop. In that case the regulator also stays in full regulation.

The controller also tracks a wait state and an active background (debug-halted) state. It leaves stop3 or wait on an interrupt, and leaves stop1 or stop2 only through reset. A background command from the debug port wakes it from any state into background mode, but only while debug is enabled. A memory-access command that arrives during stop or wait is refused and raises an error flag. A low-voltage event is turned into an interrupt pulse or a reset-request pulse, chosen by a configuration bit. The analog regulator, the voltage detector, the debug serial link and the CPU are outside the block and appear only as input strobes.

Top module: `lpstop_ctrl`

## Requirements
- R1: After a synchronous reset, `eff_lvl` is 2'b00, every bit of `periph_clk_en` is 1, `dbg_clk_en` is 1, and `reg_standby`, `mem_err`, `mem_ack`, `bkgd_active`, `in_wait`, `lvd_irq` and `lvd_rst_req` are all 0.
- R2: Level encoding is 2'b00 run, 2'b01 stop1, 2'b10 stop2, 2'b11 stop3. A `stop_req` seen at a clock edge while running, with a non-zero `stop_lvl`, changes `eff_lvl` on that same edge. A request with `stop_lvl` 2'b00, or one made outside the run state, has no effect. With neither debug nor stop-time voltage detection enabled, the requested level is entered as asked and `reg_standby` is 1.
- R3: With `dbg_en` set, a stop1 or stop2 request enters stop3 (`eff_lvl` 2'b11) and `reg_standby` stays 0.
- R4: With both `lvd_en` and `lvd_stop_en` set, a stop1 or stop2 request enters stop3 and `reg_standby` stays 0. `lvd_en` alone does not change the level.
- R5: In every stop level all bits of `periph_clk_en` are 0. `dbg_clk_en` equals `dbg_en` during stop and is 1 outside stop.
- R6: `irq_wake` ends stop3 and restores all clock enables on the sampling edge. In stop1 or stop2 it is ignored, however long it is held.
- R7: `bkgd_cmd` with `dbg_en` set enters background mode (`bkgd_active` 1, `eff_lvl` 2'b00, clocks restored) from run, wait or stop. With `dbg_en` clear it is ignored. `dbg_go` returns from background mode to run.
- R8: A `mem_cmd` during stop or wait sets `mem_err` and gives no `mem_ack`. In run or background mode it gives a one-cycle `mem_ack` and clears `mem_err`.
- R9: Entering background mode clears `mem_err`.
- R10: `lvd_trip` with `lvd_en` set, and during stop also with `lvd_stop_en` set, gives a one-cycle `lvd_irq` when `lvd_rst_sel` is 0 or a one-cycle `lvd_rst_req` when it is 1. The interrupt form also wakes stop3. A trip in stop without `lvd_stop_en`, or any trip without `lvd_en`, has no effect.
- R11: `wait_req` while running sets `in_wait` and leaves all clock enables on. `irq_wake` returns to run.
- R12: Synchronous reset from stop1 or stop2 returns every output to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop strobe from the core |
| stop_lvl | input | 2 | Requested stop level |
| wait_req | input | 1 | Wait strobe from the core |
| dbg_en | input | 1 | Debug enable |
| lvd_en | input | 1 | Low-voltage detection enable |
| lvd_stop_en | input | 1 | Keep low-voltage detection active during stop |
| lvd_rst_sel | input | 1 | Low-voltage event action: 1 reset request, 0 interrupt |
| irq_wake | input | 1 | Interrupt wake strobe |
| lvd_trip | input | 1 | Low-voltage event strobe from the detector |
| bkgd_cmd | input | 1 | Background command strobe from the debug port |
| dbg_go | input | 1 | Leave background mode strobe |
| mem_cmd | input | 1 | Memory-access-with-status command strobe |
| eff_lvl | output | 2 | Level actually entered |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_standby | output | 1 | Regulator standby control |
| mem_err | output | 1 | Refused-access flag (stop or wait) |
| mem_ack | output | 1 | Memory command accepted pulse |
| bkgd_active | output | 1 | Active background mode |
| in_wait | output | 1 | Wait state |
| lvd_irq | output | 1 | Low-voltage interrupt pulse |
| lvd_rst_req | output | 1 | Low-voltage reset request pulse |

## Verification
Every output is a register loaded from the next-state decision, so a wrong power state shows at the ports on the very edge that takes it. A missed downgrade shows as `eff_lvl` 2'b01 or 2'b10 with `reg_standby` high, even though debug or detection should keep the regulator on. A stale stop state shows as clock enables that stay low after a legal wake, or an ignored interrupt in stop3. A corrupted status register shows on the next memory command as an ack and an error flag that contradict the state `in_wait`, `bkgd_active` and `eff_lvl` report.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_RUN = 2'b00,
    LVL_S1  = 2'b01,
    LVL_S2  = 2'b10,
    LVL_S3  = 2'b11
  } stop_lvl_e;

  typedef enum logic [1:0] {
    PS_RUN,
    PS_WAIT,
    PS_STOP,
    PS_BKGD
  } pwr_state_e;
endpackage

// File: rtl/lpstop_level_sel.sv
module lpstop_level_sel
  import lpstop_pkg::*;
(
  input  logic [LVL_W-1:0] req_lvl,
  input  logic             dbg_en,
  input  logic             lvd_en,
  input  logic             lvd_stop_en,
  output logic             req_nonzero,
  output logic             keep_alive,
  output stop_lvl_e        sel_lvl
);
  logic deep_req;

  always_comb begin
    keep_alive  = dbg_en | (lvd_en & lvd_stop_en);
    req_nonzero = (req_lvl != LVL_RUN);
    deep_req    = (req_lvl == LVL_S1) || (req_lvl == LVL_S2);
    if (keep_alive && deep_req) sel_lvl = LVL_S3;
    else                        sel_lvl = stop_lvl_e'(req_lvl);
  end
endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
  import lpstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       req_nonzero,
  input  stop_lvl_e  sel_lvl,
  input  logic       wait_req,
  input  logic       wake_irq,
  input  logic       bkgd_go,
  input  logic       dbg_go,
  output pwr_state_e st_q,
  output pwr_state_e st_nxt,
  output stop_lvl_e  lvl_q
);
  stop_lvl_e lvl_nxt;

  always_comb begin
    st_nxt  = st_q;
    lvl_nxt = lvl_q;
    unique case (st_q)
      PS_RUN: begin
        if (bkgd_go) begin
          st_nxt = PS_BKGD;
        end else if (stop_req && req_nonzero) begin
          st_nxt  = PS_STOP;
          lvl_nxt = sel_lvl;
        end else if (wait_req) begin
          st_nxt = PS_WAIT;
        end
      end
      PS_WAIT: begin
        if (bkgd_go)       st_nxt = PS_BKGD;
        else if (wake_irq) st_nxt = PS_RUN;
      end
      PS_STOP: begin
        if (bkgd_go) begin
          st_nxt  = PS_BKGD;
          lvl_nxt = LVL_RUN;
        end else if (lvl_q == LVL_S3 && wake_irq) begin
          st_nxt  = PS_RUN;
          lvl_nxt = LVL_RUN;
        end
      end
      PS_BKGD: begin
        if (dbg_go) st_nxt = PS_RUN;
      end
      default: begin
        st_nxt  = PS_RUN;
        lvl_nxt = LVL_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_RUN;
      lvl_q <= LVL_RUN;
    end else begin
      st_q  <= st_nxt;
      lvl_q <= lvl_nxt;
    end
  end

  // R6: a deep stop level is never left by an interrupt
  p_deep_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_STOP && lvl_q != LVL_S3 && !bkgd_go) |=> (st_q == PS_STOP));

  // R2: the level register reads run whenever the state is not stop
  p_lvl_run_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_STOP) |-> (lvl_q == LVL_RUN));
endmodule

// File: rtl/lpstop_clk_gate.sv
module lpstop_clk_gate
  import lpstop_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pwr_state_e            st_q,
  input  pwr_state_e            st_nxt,
  input  logic                  keep_alive,
  input  logic                  dbg_en,
  output logic [NUM_PERIPH-1:0] periph_en,
  output logic                  dbg_clk_en,
  output logic                  reg_standby
);
  logic stop_nxt;
  logic stop_entry;

  assign stop_nxt   = (st_nxt == PS_STOP);
  assign stop_entry = stop_nxt && (st_q != PS_STOP);

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_pen
    always_ff @(posedge clk) begin
      if (rst) periph_en[g] <= 1'b1;
      else     periph_en[g] <= !stop_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_clk_en  <= 1'b1;
      reg_standby <= 1'b0;
    end else begin
      dbg_clk_en <= !stop_nxt || dbg_en;
      if (stop_entry)     reg_standby <= !keep_alive;
      else if (!stop_nxt) reg_standby <= 1'b0;
    end
  end

  // R5: peripheral clocks are all off in every stop level
  p_periph_off_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_STOP) |-> (periph_en == '0));

  // R1: outside stop the regulator is never in standby
  p_standby_run_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_STOP) |-> !reg_standby);
endmodule

// File: rtl/lpstop_dbg_status.sv
module lpstop_dbg_status
  import lpstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_e st_q,
  input  pwr_state_e st_nxt,
  input  logic       mem_cmd,
  output logic       mem_err,
  output logic       mem_ack,
  output logic       bkgd_active,
  output logic       in_wait
);
  logic asleep;
  logic bkgd_entry;

  assign asleep     = (st_q == PS_STOP) || (st_q == PS_WAIT);
  assign bkgd_entry = (st_nxt == PS_BKGD) && (st_q != PS_BKGD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_err     <= 1'b0;
      mem_ack     <= 1'b0;
      bkgd_active <= 1'b0;
      in_wait     <= 1'b0;
    end else begin
      bkgd_active <= (st_nxt == PS_BKGD);
      in_wait     <= (st_nxt == PS_WAIT);
      mem_ack     <= mem_cmd && !asleep;
      if (bkgd_entry)   mem_err <= 1'b0;
      else if (mem_cmd) mem_err <= asleep;
    end
  end

  // R9: the error flag is clear on the first cycle of background mode
  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bkgd_active) |-> !mem_err);

  // R8: an accepted command never coexists with the refused flag
  p_ack_err_r8: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> !mem_err);
endmodule

// File: rtl/lpstop_lvd_evt.sv
module lpstop_lvd_evt (
  input  logic clk,
  input  logic rst,
  input  logic lvd_trip,
  input  logic lvd_en,
  input  logic lvd_stop_en,
  input  logic lvd_rst_sel,
  input  logic in_stop,
  output logic lvd_wake,
  output logic lvd_irq,
  output logic lvd_rst_req
);
  logic evt_ok;

  assign evt_ok   = lvd_trip && lvd_en && (!in_stop || lvd_stop_en);
  assign lvd_wake = evt_ok && !lvd_rst_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvd_irq     <= 1'b0;
      lvd_rst_req <= 1'b0;
    end else begin
      lvd_irq     <= evt_ok && !lvd_rst_sel;
      lvd_rst_req <= evt_ok && lvd_rst_sel;
    end
  end

  // R10: one event yields either an interrupt or a reset request, never both
  p_lvd_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lvd_irq, lvd_rst_req}));
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
  import lpstop_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stop_req,
  input  logic [1:0]            stop_lvl,
  input  logic                  wait_req,
  input  logic                  dbg_en,
  input  logic                  lvd_en,
  input  logic                  lvd_stop_en,
  input  logic                  lvd_rst_sel,
  input  logic                  irq_wake,
  input  logic                  lvd_trip,
  input  logic                  bkgd_cmd,
  input  logic                  dbg_go,
  input  logic                  mem_cmd,
  output logic [1:0]            eff_lvl,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  dbg_clk_en,
  output logic                  reg_standby,
  output logic                  mem_err,
  output logic                  mem_ack,
  output logic                  bkgd_active,
  output logic                  in_wait,
  output logic                  lvd_irq,
  output logic                  lvd_rst_req
);
  logic       req_nonzero;
  logic       keep_alive;
  stop_lvl_e  sel_lvl;
  stop_lvl_e  lvl_q;
  pwr_state_e st_q;
  pwr_state_e st_nxt;
  logic       in_stop;
  logic       lvd_wake;
  logic       wake_irq;
  logic       bkgd_go;

  assign in_stop  = (st_q == PS_STOP);
  assign wake_irq = irq_wake || lvd_wake;
  assign bkgd_go  = bkgd_cmd && dbg_en;
  assign eff_lvl  = lvl_q;

  lpstop_level_sel u_sel (
    .req_lvl     (stop_lvl),
    .dbg_en      (dbg_en),
    .lvd_en      (lvd_en),
    .lvd_stop_en (lvd_stop_en),
    .req_nonzero (req_nonzero),
    .keep_alive  (keep_alive),
    .sel_lvl     (sel_lvl)
  );

  lpstop_lvd_evt u_lvd (
    .clk         (clk),
    .rst         (rst),
    .lvd_trip    (lvd_trip),
    .lvd_en      (lvd_en),
    .lvd_stop_en (lvd_stop_en),
    .lvd_rst_sel (lvd_rst_sel),
    .in_stop     (in_stop),
    .lvd_wake    (lvd_wake),
    .lvd_irq     (lvd_irq),
    .lvd_rst_req (lvd_rst_req)
  );

  lpstop_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .req_nonzero (req_nonzero),
    .sel_lvl     (sel_lvl),
    .wait_req    (wait_req),
    .wake_irq    (wake_irq),
    .bkgd_go     (bkgd_go),
    .dbg_go      (dbg_go),
    .st_q        (st_q),
    .st_nxt      (st_nxt),
    .lvl_q       (lvl_q)
  );

  lpstop_clk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .st_q        (st_q),
    .st_nxt      (st_nxt),
    .keep_alive  (keep_alive),
    .dbg_en      (dbg_en),
    .periph_en   (periph_clk_en),
    .dbg_clk_en  (dbg_clk_en),
    .reg_standby (reg_standby)
  );

  lpstop_dbg_status u_dbg (
    .clk         (clk),
    .rst         (rst),
    .st_q        (st_q),
    .st_nxt      (st_nxt),
    .mem_cmd     (mem_cmd),
    .mem_err     (mem_err),
    .mem_ack     (mem_ack),
    .bkgd_active (bkgd_active),
    .in_wait     (in_wait)
  );

  // R3: with debug enabled at entry, the entered level is stop3
  p_dbg_downgrade_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_stop) && $past(dbg_en)) |-> (eff_lvl == 2'b11));

  // R4: a deep level is only reached with the regulator allowed to sleep
  p_deep_standby_r4: assert property (@(posedge clk) disable iff (rst)
    (in_stop && eff_lvl != 2'b11) |-> reg_standby);

  // R6: leaving stop brings every peripheral clock back at once
  p_wake_restore_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(in_stop) |-> (&periph_clk_en));
endmodule

// File: tb/test_lpstop_ctrl.sv
`timescale 1ns/1ps
module test_lpstop_ctrl;
  localparam int NP = 8;
  localparam int NV = 30;

  logic          clk = 1'b0;
  logic          rst, stop_req, wait_req, dbg_en, lvd_en, lvd_stop_en, lvd_rst_sel;
  logic          irq_wake, lvd_trip, bkgd_cmd, dbg_go, mem_cmd;
  logic [1:0]    stop_lvl;
  logic [1:0]    eff_lvl;
  logic [NP-1:0] periph_clk_en;
  logic          dbg_clk_en, reg_standby, mem_err, mem_ack, bkgd_active, in_wait;
  logic          lvd_irq, lvd_rst_req;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  lpstop_ctrl #(.NUM_PERIPH(NP)) i_lpstop_ctrl (
    .clk(clk), .rst(rst), .stop_req(stop_req), .stop_lvl(stop_lvl),
    .wait_req(wait_req), .dbg_en(dbg_en), .lvd_en(lvd_en),
    .lvd_stop_en(lvd_stop_en), .lvd_rst_sel(lvd_rst_sel),
    .irq_wake(irq_wake), .lvd_trip(lvd_trip), .bkgd_cmd(bkgd_cmd),
    .dbg_go(dbg_go), .mem_cmd(mem_cmd), .eff_lvl(eff_lvl),
    .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en),
    .reg_standby(reg_standby), .mem_err(mem_err), .mem_ack(mem_ack),
    .bkgd_active(bkgd_active), .in_wait(in_wait), .lvd_irq(lvd_irq),
    .lvd_rst_req(lvd_rst_req)
  );

  // Stimulus: rst stop lvl[2] dbg lvde lvdse rsel irq trip bkgd go mem wait
  // Expected: lvl[2] periph_all dbgclk stby merr ack bkgd wait lirq lrst
  localparam logic [28:0] VEC [NV] = '{
    {14'b1_0_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd1},  // R1 reset
    {14'b0_0_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd1},  // R1 idle
    {14'b0_1_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd2},  // R2 level 0 ignored
    {14'b0_1_01_0_0_0_0_0_0_0_0_0_0, 11'b01_0_0_1_0_0_0_0_0_0, 4'd2},  // R2 stop1
    {14'b0_0_00_0_0_0_0_1_0_0_0_0_0, 11'b01_0_0_1_0_0_0_0_0_0, 4'd6},  // R6 irq ignored
    {14'b0_0_00_0_0_0_0_0_0_0_0_1_0, 11'b01_0_0_1_1_0_0_0_0_0, 4'd8},  // R8 refused
    {14'b0_0_00_0_0_0_0_0_0_1_0_0_0, 11'b01_0_0_1_1_0_0_0_0_0, 4'd7},  // R7 bkgd no dbg
    {14'b1_0_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd12}, // R12 reset exit
    {14'b0_1_10_0_0_0_0_0_0_0_0_0_0, 11'b10_0_0_1_0_0_0_0_0_0, 4'd2},  // R2 stop2
    {14'b0_0_00_0_1_0_0_0_1_0_0_0_0, 11'b10_0_0_1_0_0_0_0_0_0, 4'd10}, // R10 no stop enable
    {14'b1_0_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd12}, // R12
    {14'b0_1_01_1_0_0_0_0_0_0_0_0_0, 11'b11_0_1_0_0_0_0_0_0_0, 4'd3},  // R3 stop1 -> stop3
    {14'b0_0_00_1_0_0_0_1_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd6},  // R6 stop3 wake
    {14'b0_1_10_1_0_0_0_0_0_0_0_0_0, 11'b11_0_1_0_0_0_0_0_0_0, 4'd3},  // R3 stop2 -> stop3
    {14'b0_0_00_1_0_0_0_0_0_0_0_1_0, 11'b11_0_1_0_1_0_0_0_0_0, 4'd8},  // R8 refused
    {14'b0_0_00_1_0_0_0_0_0_1_0_0_0, 11'b00_1_1_0_0_0_1_0_0_0, 4'd9},  // R9/R7 background
    {14'b0_0_00_1_0_0_0_0_0_0_0_1_0, 11'b00_1_1_0_0_1_1_0_0_0, 4'd8},  // R8 accepted
    {14'b0_0_00_1_0_0_0_0_0_0_1_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd7},  // R7 go
    {14'b0_1_01_0_1_1_0_0_0_0_0_0_0, 11'b11_0_0_0_0_0_0_0_0_0, 4'd4},  // R4 lvd downgrade
    {14'b0_0_00_0_1_1_0_0_1_0_0_0_0, 11'b00_1_1_0_0_0_0_0_1_0, 4'd10}, // R10 irq wakes
    {14'b0_1_10_0_1_0_0_0_0_0_0_0_0, 11'b10_0_0_1_0_0_0_0_0_0, 4'd4},  // R4 lvde alone
    {14'b1_0_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd12}, // R12
    {14'b0_1_11_0_1_1_0_0_0_0_0_0_0, 11'b11_0_0_0_0_0_0_0_0_0, 4'd2},  // R2 stop3
    {14'b0_0_00_0_1_1_1_0_1_0_0_0_0, 11'b11_0_0_0_0_0_0_0_0_1, 4'd10}, // R10 reset req
    {14'b0_0_00_0_0_0_0_1_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 4'd6},  // R6 wake
    {14'b0_0_00_0_0_0_0_0_0_0_0_0_1, 11'b00_1_1_0_0_0_0_1_0_0, 4'd11}, // R11 wait
    {14'b0_0_00_0_0_0_0_0_0_0_0_1_0, 11'b00_1_1_0_1_0_0_1_0_0, 4'd8},  // R8 refused in wait
    {14'b0_0_00_0_0_0_0_1_0_0_0_0_0, 11'b00_1_1_0_1_0_0_0_0_0, 4'd11}, // R11 exit wait
    {14'b0_0_00_0_0_0_0_0_0_0_0_1_0, 11'b00_1_1_0_0_1_0_0_0_0, 4'd8},  // R8 accepted
    {14'b0_0_00_0_1_0_0_0_1_0_0_0_0, 11'b00_1_1_0_0_0_0_0_1_0, 4'd10}  // R10 run event
  };

  task automatic put(input logic [13:0] v);
    rst         = v[13];
    stop_req    = v[12];
    stop_lvl    = v[11:10];
    dbg_en      = v[9];
    lvd_en      = v[8];
    lvd_stop_en = v[7];
    lvd_rst_sel = v[6];
    irq_wake    = v[5];
    lvd_trip    = v[4];
    bkgd_cmd    = v[3];
    dbg_go      = v[2];
    mem_cmd     = v[1];
    wait_req    = v[0];
  endtask

  function automatic logic [10:0] observe(input logic exp_p);
    logic p;
    if (periph_clk_en == '1)      p = 1'b1;
    else if (periph_clk_en == '0) p = 1'b0;
    else                          p = ~exp_p;
    return {eff_lvl, p, dbg_clk_en, reg_standby, mem_err, mem_ack,
            bkgd_active, in_wait, lvd_irq, lvd_rst_req};
  endfunction

  task automatic step_check(input logic [13:0] v, input logic [10:0] e,
                            input int rq);
    logic [10:0] act;
    @(negedge clk);
    put(v);
    @(posedge clk);
    #1;
    act = observe(e[8]);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL R%0d: got %b expected %b", rq, act, e);
    end
  endtask

  initial begin
    put(14'b1_0_00_0_0_0_0_0_0_0_0_0_0);
    repeat (3) @(posedge clk);
    for (int k = 0; k < NV; k++) begin
      step_check(VEC[k][28:15], VEC[k][14:4], int'(VEC[k][3:0]));
    end

    // R9: error flag set in wait, cleared by entering background from wait
    step_check(14'b0_0_00_1_0_0_0_0_0_0_0_0_1, 11'b00_1_1_0_0_0_0_1_0_0, 11);
    step_check(14'b0_0_00_1_0_0_0_0_0_0_0_1_0, 11'b00_1_1_0_1_0_0_1_0_0, 8);
    step_check(14'b0_0_00_1_0_0_0_0_0_1_0_0_0, 11'b00_1_1_0_0_0_1_0_0_0, 9);
    // R2: stop request during background mode has no effect
    step_check(14'b0_1_01_1_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_1_0_0_0, 2);
    step_check(14'b0_0_00_1_0_0_0_0_0_0_1_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 7);
    // R6: interrupt held for several cycles in stop1 never wakes it
    step_check(14'b0_1_01_0_0_0_0_0_0_0_0_0_0, 11'b01_0_0_1_0_0_0_0_0_0, 2);
    for (int k = 0; k < 4; k++) begin
      step_check(14'b0_0_00_0_0_0_0_1_0_0_0_0_0, 11'b01_0_0_1_0_0_0_0_0_0, 6);
    end
    // R12: reset brings stop1 back to defaults
    step_check(14'b1_0_00_0_0_0_0_0_0_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 12);
    // R10: trip with detection disabled is ignored
    step_check(14'b0_0_00_0_0_1_0_0_1_0_0_0_0, 11'b00_1_1_0_0_0_0_0_0_0, 10);
    // R5: debug clock follows debug enable inside stop3 downgraded by detection
    step_check(14'b0_1_10_0_1_1_0_0_0_0_0_0_0, 11'b11_0_0_0_0_0_0_0_0_0, 5);
    step_check(14'b0_0_00_1_1_1_0_0_0_0_0_0_0, 11'b11_0_1_0_0_0_0_0_0_0, 5);
    // R7: background command wakes stop3 once debug is enabled
    step_check(14'b0_0_00_1_1_1_0_0_0_1_0_0_0, 11'b00_1_1_0_0_0_1_0_0_0, 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule